// File: doc/BRIEF.md
# Voltage-Code Power-Good Window Monitor

This block turns a 4-bit voltage-select code into a target output voltage in millivolts. It then judges a stream of digitized output-voltage samples against a window of plus and minus a fixed percentage around that target. The result drives a power-good line with open-drain semantics. A high `pwrOk` releases the line and a low `pwrOk` pulls it down. A sample only counts when its valid strobe is high. The last judged status holds between strobes.

Any change in status must persist for a programmable number of clock cycles before the output follows it. A short excursion into or out of the window is therefore filtered. A code outside the permitted range raises an invalid flag and holds the line low. A change of code pulls the line low at once. The new window must then be qualified from fresh samples before the line is released.

Top module: `pg_window_monitor`

## Requirements
- R1: For codes 5 to 15 (bit 3 is the most significant bit), the target is 1300 + 50 × (15 − code) mV. Code 15 gives 1300 mV and code 5 gives 1800 mV. A sample equal to the target qualifies as in-window.
- R2: Codes 0 to 4 raise `invalidCode` in the same cycle, combinationally from `vidCode`. They drive `pwrOk` low from the next rising clock edge and keep it low for as long as such a code is applied, whatever the samples are.
- R3: The lower limit is the target × (100 − WIN_PCT) / 100, rounded up to a whole millivolt. A sample equal to the limit is in-window. A sample one millivolt below it is out of window.
- R4: The upper limit is the target × (100 + WIN_PCT) / 100, rounded down to a whole millivolt. A sample equal to the limit is in-window. A sample one millivolt above it is out of window.
- R5: A sample presented while `senseValid` is low has no effect. The status judged from the last valid sample is kept until the next valid sample.
- R6: Suppose `pwrOk` is low and the code is steady and valid. If in-window valid samples are applied from one clock edge onward, `pwrOk` goes high at the (DELAY_CYCLES + 1)-th rising edge, counting that edge as the first.
- R7: Suppose `pwrOk` is high and the code is steady. If out-of-window valid samples are applied from one clock edge onward, `pwrOk` goes low at the (DELAY_CYCLES + 1)-th rising edge, counting that edge as the first.
- R8: A status opposite to `pwrOk` that lasts fewer than DELAY_CYCLES cycles leaves `pwrOk` unchanged.
- R9: A change of `vidCode` drives `pwrOk` low at the next rising edge and clears the judged status. With in-window samples present, `pwrOk` rises again DELAY_CYCLES + 2 edges after the change, counting the first edge that sees the new code.
- R10: During and right after reset, `pwrOk` is low. It rises only through the qualification of R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vidCode | input | 4 | Voltage-select code; an unconnected bit is expected to read as 1 |
| senseMv | input | MV_W | Sensed output voltage in millivolts |
| senseValid | input | 1 | High when `senseMv` carries a new sample |
| pwrOk | output | 1 | 1 releases the open-drain power-good line, 0 pulls it low |
| invalidCode | output | 1 | High while `vidCode` is a disallowed code |

## Verification
A wrong decoded target or an off-by-one limit would show as a wrong `pwrOk` level. It appears DELAY_CYCLES + 1 edges after a boundary sample, so every permitted code is swept with samples on and one millivolt past each limit. A qualification counter that is off by one, or that is not cleared, shows as `pwrOk` moving one edge early or late, or as a filtered glitch leaking through. Both are checked on the exact edge. A held-over status after a code change shows as `pwrOk` staying high on the edge after the change.

// File: rtl/pg_mon_pkg.sv
package pg_mon_pkg;
  localparam int VID_W    = 4;
  localparam int BASE_MV  = 1300;
  localparam int STEP_MV  = 50;
  localparam int TOP_CODE = (1 << VID_W) - 1;
  localparam int MIN_CODE = 5;

  // status from datapath to control
  typedef struct packed {
    logic inWin;
    logic codeChg;
    logic codeBad;
  } pgStat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrWin;
  } pgStrobe_t;

  function automatic int targetMv(input logic [VID_W-1:0] code);
    if (int'(code) < MIN_CODE) return 0;
    return BASE_MV + STEP_MV * (TOP_CODE - int'(code));
  endfunction
endpackage

// File: rtl/pg_window_path.sv
module pg_window_path
  import pg_mon_pkg::*;
#(
  parameter int MV_W    = 12,
  parameter int WIN_PCT = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VID_W-1:0] vidCode,
  input  logic [MV_W-1:0]  senseMv,
  input  logic             senseValid,
  input  pgStrobe_t        strobe,
  output pgStat_t          stat
);
  localparam int PCT_DEN  = 100;
  localparam int LO_SCALE = PCT_DEN - WIN_PCT;
  localparam int HI_SCALE = PCT_DEN + WIN_PCT;

  logic [VID_W-1:0] vidQ;
  logic             winQ;
  logic             sampleIn;
  int               tgtMv;
  int               loMv;
  int               hiMv;

  // limits rounded toward the inside of the window
  always_comb begin
    tgtMv    = targetMv(vidCode);
    loMv     = (tgtMv * LO_SCALE + PCT_DEN - 1) / PCT_DEN;
    hiMv     = (tgtMv * HI_SCALE) / PCT_DEN;
    sampleIn = (int'(senseMv) >= loMv) && (int'(senseMv) <= hiMv);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vidQ <= '1;
      winQ <= 1'b0;
    end else begin
      vidQ <= vidCode;
      if (strobe.clrWin)   winQ <= 1'b0;
      else if (senseValid) winQ <= sampleIn;
    end
  end

  always_comb begin
    stat.inWin   = winQ;
    stat.codeChg = (vidCode != vidQ);
    stat.codeBad = (int'(vidCode) < MIN_CODE);
  end
endmodule

// File: rtl/pg_qual_ctrl.sv
module pg_qual_ctrl
  import pg_mon_pkg::*;
#(
  parameter int DELAY_CYCLES = 5000
) (
  input  logic      clk,
  input  logic      rstN,
  input  pgStat_t   stat,
  output pgStrobe_t strobe,
  output logic      pwrOk
);
  localparam int               CNT_W    = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] qualCnt;
  logic             forceLow;

  assign forceLow = stat.codeBad | stat.codeChg;

  always_comb strobe.clrWin = forceLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrOk   <= 1'b0;
      qualCnt <= '0;
    end else if (forceLow) begin
      pwrOk   <= 1'b0;
      qualCnt <= '0;
    end else if (stat.inWin == pwrOk) begin
      qualCnt <= '0;
    end else if (qualCnt == CNT_LAST) begin
      pwrOk   <= stat.inWin;
      qualCnt <= '0;
    end else begin
      qualCnt <= qualCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pg_window_monitor.sv
module pg_window_monitor
  import pg_mon_pkg::*;
#(
  parameter int MV_W         = 12,
  parameter int WIN_PCT      = 11,
  parameter int DELAY_CYCLES = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VID_W-1:0] vidCode,
  input  logic [MV_W-1:0]  senseMv,
  input  logic             senseValid,
  output logic             pwrOk,
  output logic             invalidCode
);
  pgStat_t   stat;
  pgStrobe_t strobe;

  pg_window_path #(.MV_W(MV_W), .WIN_PCT(WIN_PCT)) path_i (
    .clk(clk), .rstN(rstN), .vidCode(vidCode), .senseMv(senseMv),
    .senseValid(senseValid), .strobe(strobe), .stat(stat)
  );

  pg_qual_ctrl #(.DELAY_CYCLES(DELAY_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .stat(stat), .strobe(strobe), .pwrOk(pwrOk)
  );

  assign invalidCode = stat.codeBad;
endmodule

// File: rtl/pg_window_monitor_chk.sv
module pg_window_monitor_chk #(
  parameter int DELAY_CYCLES = 5000
) (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] vidCode,
  input logic       invalidCode,
  input logic       pwrOk
);
  localparam int               RUN_W   = $clog2(DELAY_CYCLES + 2);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(DELAY_CYCLES);

  logic [RUN_W-1:0] lowRun;
  logic [RUN_W-1:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= '0;
    end else begin
      lowRun  <= pwrOk ? '0 : ((lowRun == RUN_SAT) ? lowRun : lowRun + 1'b1);
      highRun <= !pwrOk ? '0 : ((highRun == RUN_SAT) ? highRun : highRun + 1'b1);
    end
  end

  AST_BAD_CODE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    invalidCode |=> !pwrOk); // R2

  AST_CODE_CHANGE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (vidCode != $past(vidCode)) |=> !pwrOk); // R9

  AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrOk) |-> (lowRun >= RUN_SAT)); // R6

  AST_FALL_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pwrOk) && !$past(invalidCode) && ($past(vidCode) == $past(vidCode, 2)))
      |-> (highRun >= RUN_SAT)); // R7
endmodule

bind pg_window_monitor pg_window_monitor_chk #(.DELAY_CYCLES(DELAY_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .vidCode(vidCode), .invalidCode(invalidCode), .pwrOk(pwrOk)
);

// File: tb/pg_window_monitor_tb_top.sv
`timescale 1ns/1ps
module pg_window_monitor_tb_top;
  localparam int MV_W  = 12;
  localparam int PCT   = 11;
  localparam int DLY   = 6;
  localparam int LONG  = DLY + 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [3:0]      vidCode = 4'hF;
  logic [MV_W-1:0] senseMv = '0;
  logic            senseValid = 1'b0;
  logic            pwrOk;
  logic            invalidCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pg_window_monitor #(.MV_W(MV_W), .WIN_PCT(PCT), .DELAY_CYCLES(DLY)) dut_i (
    .clk(clk), .rstN(rstN), .vidCode(vidCode), .senseMv(senseMv),
    .senseValid(senseValid), .pwrOk(pwrOk), .invalidCode(invalidCode)
  );

  function automatic int tgtOf(input int c);
    return 1300 + 50 * (15 - c);
  endfunction
  function automatic int loOf(input int c);
    return (tgtOf(c) * (100 - PCT) + 99) / 100;
  endfunction
  function automatic int hiOf(input int c);
    return (tgtOf(c) * (100 + PCT)) / 100;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int c, input int mv, input bit v);
    vidCode    = 4'(c);
    senseMv    = MV_W'(mv);
    senseValid = v;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 0, 1);
    finishRun();
  end

  initial begin
    // R10: reset state
    cyc(3);
    chk("R10 pwrOk in reset", int'(pwrOk), 0);
    chk("R10 invalidCode in reset", int'(invalidCode), 0);
    rstN = 1'b1;
    cyc(2);
    chk("R10 pwrOk after reset", int'(pwrOk), 0);

    // R6: exact rise edge
    drive(15, 1300, 1'b1);
    cyc(DLY);
    chk("R6 before rise", int'(pwrOk), 0);
    cyc(1);
    chk("R6 rise edge", int'(pwrOk), 1);

    // R7: exact fall edge
    drive(15, hiOf(15) + 1, 1'b1);
    cyc(DLY);
    chk("R7 before fall", int'(pwrOk), 1);
    cyc(1);
    chk("R7 fall edge", int'(pwrOk), 0);

    // R8: short excursions filtered both ways
    drive(15, 1300, 1'b1); cyc(3);
    drive(15, 900, 1'b1);  cyc(LONG);
    chk("R8 short in-window while low", int'(pwrOk), 0);
    drive(15, 1300, 1'b1); cyc(LONG);
    drive(15, 900, 1'b1);  cyc(DLY - 2);
    drive(15, 1300, 1'b1); cyc(LONG);
    chk("R8 short dip while high", int'(pwrOk), 1);

    // R5: samples without strobe ignored, last status held
    drive(15, 0, 1'b0); cyc(3 * DLY);
    chk("R5 unstrobed sample ignored", int'(pwrOk), 1);
    drive(15, 0, 1'b1); cyc(1);
    drive(15, 1300, 1'b0); cyc(LONG);
    chk("R5 last valid status held", int'(pwrOk), 0);

    // R1 R3 R4: sweep of every permitted code
    for (int c = 15; c >= 5; c--) begin
      drive(c, tgtOf(c), 1'b1); cyc(LONG);
      chk($sformatf("R1 target code %0d", c), int'(pwrOk), 1);
      chk($sformatf("R2 flag clear code %0d", c), int'(invalidCode), 0);
      for (int p = 0; p < 4; p++) begin
        int mv;
        int exp;
        mv  = (p == 0) ? loOf(c) : (p == 1) ? loOf(c) - 1 : (p == 2) ? hiOf(c) : hiOf(c) + 1;
        exp = (p == 0 || p == 2) ? 1 : 0;
        drive(c, tgtOf(c), 1'b1); cyc(LONG);
        drive(c, mv, 1'b1);       cyc(LONG);
        chk($sformatf("%s code %0d mv %0d", (p < 2) ? "R3" : "R4", c, mv), int'(pwrOk), exp);
      end
    end

    // R2: disallowed codes
    for (int c = 0; c < 5; c++) begin
      drive(5, 1800, 1'b1); cyc(LONG);
      drive(c, 1800, 1'b1); #1;
      chk($sformatf("R2 flag code %0d", c), int'(invalidCode), 1);
      cyc(1);
      chk($sformatf("R2 low next edge code %0d", c), int'(pwrOk), 0);
      cyc(LONG);
      chk($sformatf("R2 held low code %0d", c), int'(pwrOk), 0);
    end

    // R9: code change requalification
    drive(9, 1650, 1'b1); cyc(LONG);
    chk("R9 qualified before change", int'(pwrOk), 1);
    drive(8, 1650, 1'b1); cyc(1);
    chk("R9 low after change", int'(pwrOk), 0);
    cyc(DLY);
    chk("R9 still low", int'(pwrOk), 0);
    cyc(1);
    chk("R9 requalified", int'(pwrOk), 1);

    finishRun();
  end
endmodule